// File: doc/BRIEF.md
# Scanning Converter Sequencer with Per-Channel Window Watchdog

This block controls a multi-channel analog-to-digital converter through a byte-wide register port. One start command makes it step through channels 0, 1, 2 and so on, up to a programmed highest channel. The block requests one conversion at a time from the converter and waits for each result. It stores every result in a buffer that belongs to that channel, and software reads each buffer as a high byte and a low byte. Every stored result can be compared against a 10-bit window. Only channels whose watchdog enable bit is set can raise an event. An event on a channel sets that channel's status bit and also sets a global watchdog flag.

The converter is turned on in two steps. The first write of the on bit only wakes the block. A later write of the same bit, made while the block is on and idle, starts one scan. While a scan runs, the channel field of the control/status register shows the channel being converted. When the scan ends, that field holds the highest channel again. To clear a flag, software writes the whole control/status register, with the flag bit at 0 and the highest channel in the channel field. A single interrupt line combines the end-of-scan source and the watchdog source, each gated by its own enable.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset every register reads 0, and irq and conv_req are 0. Register map (byte addresses):
  - 0: control/status, with bit 7 end-of-scan flag, bit 6 watchdog flag, bit 5 end-of-scan interrupt enable, bit 4 watchdog interrupt enable, bits 3:0 channel.
  - 1: config, with bit 0 on/start and bit 1 right alignment.
  - 2 and 3: upper threshold bits 9:2 and bits 1:0.
  - 4 and 5: lower threshold, split the same way.
  - 6 and 7: watchdog enable bits 9:8 and bits 7:0.
  - 8 and 9: watchdog status bits 9:8 and bits 7:0.
  - 16+2n and 17+2n: high byte and low byte of the buffer for channel n.
- R2: The first write of config bit 0 = 1 issues no conversion request. A later write of bit 0 = 1, made while the block is on and idle, starts a scan.
- R3: A scan requests channels 0, 1, … up to the channel field, in order. It makes one request at a time and holds each request until conv_valid. A channel field of 0 converts channel 0 only. After the scan, the channel field reads back the highest channel.
- R4: Each result is stored in its own channel's buffer. With right alignment, the high byte is {6'b0, d[9:8]} and the low byte is d[7:0]. With left alignment, the high byte is d[9:2] and the low byte is {d[1:0], 6'b0}.
- R5: The end-of-scan flag is set once, in the cycle after the last channel's result is stored, and never earlier in the scan.
- R6: A sample fires the watchdog when it is strictly below the lower threshold or strictly above the upper threshold. A sample equal to either threshold does not fire.
- R7: A result from a channel whose enable bit is 0 never fires the watchdog.
- R8: A watchdog event on channel n sets status bit n and the watchdog flag. Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R9: A write to the control/status register clears a flag where the data bit is 0 and keeps it where the bit is 1. The same write stores both interrupt enables and the channel field. If hardware sets a flag in the same cycle, the set wins.
- R10: irq = (end-of-scan flag AND its enable) OR (watchdog flag AND its enable).
- R11: Each start runs exactly one scan. After the scan, no further request is made until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Combined interrupt |
| conv_req | output | 1 | Conversion request, held until conv_valid |
| conv_ch | output | 4 | Channel to convert |
| conv_data | input | 10 | Conversion result |
| conv_valid | input | 1 | Result strobe for the current request |

## Verification
A wrong channel counter appears at once on conv_ch during the scan. The response order recorded in the bench catches it at the first misplaced channel, and a skipped or repeated buffer shows up when the buffers are read back after end-of-scan. A faulty window compare or a faulty enable gate changes one watchdog status bit. That bit is read back after every scan, so the fault is found within that scan. An end-of-scan flag raised too early shows as irq going high before the final result strobe. A lost start or an extra start shows as a missing or surplus request within the following twenty cycles.

// File: rtl/adc_scan_pkg.sv
// Shared constants for the scanning converter sequencer: register byte
// addresses, control/status bit positions, sample width and sequencer states.
package adc_scan_pkg;
    localparam int unsigned SMP_W = 10;
    localparam int unsigned AW    = 6;

    localparam logic [AW-1:0] A_CSR    = 6'd0;
    localparam logic [AW-1:0] A_CFG    = 6'd1;
    localparam logic [AW-1:0] A_HTH_H  = 6'd2;
    localparam logic [AW-1:0] A_HTH_L  = 6'd3;
    localparam logic [AW-1:0] A_LTH_H  = 6'd4;
    localparam logic [AW-1:0] A_LTH_L  = 6'd5;
    localparam logic [AW-1:0] A_EN_H   = 6'd6;
    localparam logic [AW-1:0] A_EN_L   = 6'd7;
    localparam logic [AW-1:0] A_WST_H  = 6'd8;
    localparam logic [AW-1:0] A_WST_L  = 6'd9;
    localparam logic [AW-1:0] A_BUF0   = 6'd16;

    localparam int unsigned B_EOC   = 7;
    localparam int unsigned B_AWD   = 6;
    localparam int unsigned B_EOCIE = 5;
    localparam int unsigned B_AWDIE = 4;

    typedef enum logic {SQ_IDLE, SQ_CONV} sq_state_t;
endpackage

// File: rtl/adc_win_chk.sv
// Window comparator: flags a sample lying strictly outside [lo, hi].
// Assumes unsigned samples; equality with a bound counts as inside.
module adc_win_chk #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         outside
);
    // Strict comparison on both bounds.
    always_comb outside = (sample < lo) || (sample > hi);
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer: on start, requests channels 0..last one at a time and
// advances only on the result strobe. Assumes start is ignored while busy
// and that last is clamped to the channel count.
module adc_scan_seq #(
    parameter int unsigned NCH = 10,
    parameter int unsigned CHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] last_in,
    input  logic           res_valid,
    output logic           busy,
    output logic [CHW-1:0] cur_ch,
    output logic           store,
    output logic           done
);
    import adc_scan_pkg::*;
    localparam logic [CHW-1:0] TOP_CH = CHW'(NCH - 1);

    sq_state_t      state_q;
    logic [CHW-1:0] ch_q, last_q;

    // Sequencer state, current channel and captured highest channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ch_q    <= '0;
            last_q  <= '0;
        end else if (state_q == SQ_IDLE) begin
            if (start) begin
                state_q <= SQ_CONV;
                ch_q    <= '0;
                last_q  <= (last_in > TOP_CH) ? TOP_CH : last_in;
            end
        end else if (res_valid) begin
            if (ch_q == last_q) state_q <= SQ_IDLE;
            else                ch_q    <= ch_q + 1'b1;
        end
    end

    // Handshake outputs and per-result strobes.
    always_comb begin
        busy   = (state_q == SQ_CONV);
        cur_ch = ch_q;
        store  = busy && res_valid;
        done   = store && (ch_q == last_q);
    end
endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result buffers with read formatting. Stores raw samples and
// applies right or left alignment when a byte is read.
module adc_result_bank #(
    parameter int unsigned NCH = 10,
    parameter int unsigned CHW = 4,
    parameter int unsigned W   = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [W-1:0]   wr_data,
    input  logic [CHW-1:0] rd_ch,
    input  logic           align_right,
    output logic [7:0]     rd_hi,
    output logic [7:0]     rd_lo
);
    localparam int unsigned PAD = 16 - W;

    logic [W-1:0] buf_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_buf
        // One buffer register per channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 buf_q[g] <= '0;
            else if (wr_en && (wr_ch == CHW'(g)))       buf_q[g] <= wr_data;
        end
    end

    logic [W-1:0]  sel;
    logic [15:0]   packed16;

    // Select and align the addressed buffer.
    always_comb begin
        sel      = (rd_ch < CHW'(NCH)) ? buf_q[rd_ch] : '0;
        packed16 = align_right ? {{PAD{1'b0}}, sel} : {sel, {PAD{1'b0}}};
        rd_hi    = packed16[15:8];
        rd_lo    = packed16[7:0];
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
// Register-mapped scanning converter controller with per-channel window
// watchdog. Assumes NCH <= 10 (enable/status fit two bytes, channel 4 bits)
// and a converter that answers each held request with one valid strobe.
module adc_scan_ctrl #(
    parameter int unsigned NCH = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [5:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       conv_req,
    output logic [3:0] conv_ch,
    input  logic [9:0] conv_data,
    input  logic       conv_valid
);
    import adc_scan_pkg::*;
    localparam int unsigned CHW = 4;
    localparam logic [AW-1:0] A_BUF_END = A_BUF0 + AW'(2 * NCH);

    logic             eoc_q, awd_q, eocie_q, awdie_q, pwr_q, alr_q;
    logic [CHW-1:0]   chf_q;
    logic [SMP_W-1:0] hth_q, lth_q;
    logic [NCH-1:0]   en_q, wst_q;

    logic             busy, store, done, outside, evt, start;
    logic [CHW-1:0]   cur_ch, rd_ch;
    logic [NCH-1:0]   evt_vec;
    logic [7:0]       buf_hi, buf_lo;
    logic [AW-1:0]    buf_off;
    logic [15:0]      en16, wst16, wmask;

    // Decode a start: on-bit written while already on and idle.
    always_comb start = reg_wr && (reg_addr == A_CFG) && reg_wdata[0] && pwr_q && !busy;

    adc_scan_seq #(.NCH(NCH), .CHW(CHW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .last_in(chf_q),
        .res_valid(conv_valid), .busy(busy), .cur_ch(cur_ch),
        .store(store), .done(done)
    );

    adc_win_chk #(.W(SMP_W)) u_win (
        .sample(conv_data), .lo(lth_q), .hi(hth_q), .outside(outside)
    );

    adc_result_bank #(.NCH(NCH), .CHW(CHW), .W(SMP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(store), .wr_ch(cur_ch),
        .wr_data(conv_data), .rd_ch(rd_ch), .align_right(alr_q),
        .rd_hi(buf_hi), .rd_lo(buf_lo)
    );

    // Gate the window result by the channel's enable bit.
    always_comb begin
        evt     = store && en_q[cur_ch] && outside;
        evt_vec = evt ? (NCH'(1) << cur_ch) : '0;
    end

    // Control/status register: software write first, hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q <= 1'b0; awd_q <= 1'b0; eocie_q <= 1'b0; awdie_q <= 1'b0;
            chf_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CSR) begin
                eoc_q   <= eoc_q & reg_wdata[B_EOC];
                awd_q   <= awd_q & reg_wdata[B_AWD];
                eocie_q <= reg_wdata[B_EOCIE];
                awdie_q <= reg_wdata[B_AWDIE];
                if (!busy) chf_q <= reg_wdata[CHW-1:0];
            end
            if (done) begin
                eoc_q <= 1'b1;
                chf_q <= cur_ch;
            end
            if (evt) awd_q <= 1'b1;
        end
    end

    // Configuration: power/wake and alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b0; alr_q <= 1'b0;
        end else if (reg_wr && reg_addr == A_CFG) begin
            pwr_q <= reg_wdata[0];
            alr_q <= reg_wdata[1];
        end
    end

    // Window thresholds, each split as bits 9:2 and bits 1:0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hth_q <= '0; lth_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_HTH_H: hth_q[9:2] <= reg_wdata;
                A_HTH_L: hth_q[1:0] <= reg_wdata[1:0];
                A_LTH_H: lth_q[9:2] <= reg_wdata;
                A_LTH_L: lth_q[1:0] <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Build the write-zero-to-clear mask for the status word.
    always_comb begin
        en16  = 16'(en_q);
        wst16 = 16'(wst_q);
        wmask = 16'hFFFF;
        if (reg_wr && reg_addr == A_WST_H) wmask[15:8] = reg_wdata;
        if (reg_wr && reg_addr == A_WST_L) wmask[7:0]  = reg_wdata;
    end

    // Watchdog enables and per-channel status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0; wst_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_EN_H) en_q <= NCH'({reg_wdata, en16[7:0]});
            if (reg_wr && reg_addr == A_EN_L) en_q <= NCH'({en16[15:8], reg_wdata});
            wst_q <= (wst_q & wmask[NCH-1:0]) | evt_vec;
        end
    end

    // Read multiplexer; buffer bytes are high at even, low at odd offsets.
    always_comb begin
        buf_off   = reg_addr - A_BUF0;
        rd_ch     = buf_off[CHW:1];
        reg_rdata = '0;
        case (reg_addr)
            A_CSR:   reg_rdata = {eoc_q, awd_q, eocie_q, awdie_q, busy ? cur_ch : chf_q};
            A_CFG:   reg_rdata = {6'b0, alr_q, pwr_q};
            A_HTH_H: reg_rdata = hth_q[9:2];
            A_HTH_L: reg_rdata = {6'b0, hth_q[1:0]};
            A_LTH_H: reg_rdata = lth_q[9:2];
            A_LTH_L: reg_rdata = {6'b0, lth_q[1:0]};
            A_EN_H:  reg_rdata = en16[15:8];
            A_EN_L:  reg_rdata = en16[7:0];
            A_WST_H: reg_rdata = wst16[15:8];
            A_WST_L: reg_rdata = wst16[7:0];
            default:
                if (reg_addr >= A_BUF0 && reg_addr < A_BUF_END)
                    reg_rdata = buf_off[0] ? buf_lo : buf_hi;
        endcase
    end

    // Output drive.
    always_comb begin
        irq      = (eoc_q && eocie_q) || (awd_q && awdie_q);
        conv_req = busy;
        conv_ch  = cur_ch;
    end
endmodule

// File: rtl/adc_scan_chk.sv
// Protocol and flag checker for adc_scan_ctrl, attached by bind.
// Assumes the converter answers only while a request is held.
module adc_scan_chk #(
    parameter int unsigned NCH = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           conv_req,
    input logic [3:0]     conv_ch,
    input logic           conv_valid,
    input logic           eoc,
    input logic           awd,
    input logic [NCH-1:0] wst
);
    AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_ch < 4'(NCH)));                                  // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_valid) |=> (conv_req && $stable(conv_ch)));      // R3
    AST_CH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(conv_req && conv_valid) && conv_req) |-> (conv_ch == $past(conv_ch) + 4'd1)); // R3
    AST_EOC_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> $past(conv_req && conv_valid));                      // R5
    AST_EOC_AT_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_req) |-> eoc);                                           // R5
    AST_WST_ONE_PER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wst & ~$past(wst)));                                       // R8
    AST_WST_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((wst & ~$past(wst)) != '0) |-> ($past(conv_req && conv_valid) && awd)); // R8
endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_valid(conv_valid), .eoc(eoc_q), .awd(awd_q), .wst(wst_q)
);

// File: tb/test_adc_scan_ctrl.sv
// Bench for adc_scan_ctrl: behavioural converter responder, directed corner
// cases and seeded random scans, checked against bench-computed expectations.
module test_adc_scan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, conv_req;
    logic [3:0] conv_ch;
    logic [9:0] conv_data = '0;
    logic       conv_valid = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ch_val [0:9];
    int seen_ch [0:31];
    bit irq_at [0:31];
    int n_seen = 0;

    adc_scan_ctrl i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_data(conv_data),
        .conv_valid(conv_valid)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // Behavioural converter: answers each held request after 0..2 cycles.
    initial begin
        forever begin
            @(negedge clk);
            conv_valid = 1'b0;
            if (conv_req) begin
                repeat ($urandom % 3) @(negedge clk);
                if (n_seen < 32) begin
                    seen_ch[n_seen] = int'(conv_ch);
                    irq_at[n_seen]  = irq;
                end
                n_seen++;
                conv_data  = 10'(ch_val[conv_ch]);
                conv_valid = 1'b1;
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic set_thr(input int lo, input int hi);
        wr(6'd2, 8'(hi >> 2)); wr(6'd3, 8'(hi & 3));
        wr(6'd4, 8'(lo >> 2)); wr(6'd5, 8'(lo & 3));
    endtask

    task automatic set_en(input int en);
        wr(6'd6, 8'(en >> 8)); wr(6'd7, 8'(en & 255));
    endtask

    task automatic rd_wst(output int v);
        int h, l;
        rd(6'd8, h); rd(6'd9, l);
        v = ((h & 3) << 8) | l;
    endtask

    // Start a scan and wait for the end-of-scan flag.
    task automatic run_scan(input bit right);
        int v;
        n_seen = 0;
        wr(6'd1, {6'b0, right, 1'b1});
        for (int i = 0; i < 400; i++) begin
            rd(6'd0, v);
            if (v[7]) break;
        end
        chk("R5 end-of-scan flag set", (v >> 7) & 1, 1);
    endtask

    function automatic int exp_hi(input int v, input bit right);
        return right ? (v >> 8) : (v >> 2);
    endfunction
    function automatic int exp_lo(input int v, input bit right);
        return right ? (v & 255) : ((v & 3) << 6);
    endfunction
    function automatic bit fires(input int v, input int lo, input int hi);
        return (v < lo) || (v > hi);
    endfunction

    initial begin
        int v, w, last, en, lo, hi;
        bit right;
        v = $urandom(32'd20240611);
        for (int i = 0; i < 10; i++) ch_val[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(6'd0, v); chk("R1 control/status after reset", v, 0);
        rd(6'd9, v); chk("R1 status after reset", v, 0);
        rd(6'd16, v); chk("R1 buffer after reset", v, 0);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 conv_req after reset", int'(conv_req), 0);

        // R2: wake write issues no request.
        set_thr(300, 800);
        set_en(32'h010);
        wr(6'd0, 8'h04);
        wr(6'd1, 8'h03);
        repeat (10) @(negedge clk);
        chk("R2 no request after wake", n_seen + int'(conv_req), 0);

        // Directed scan 0..4, channel 2 out of window but disabled.
        ch_val[0] = 11; ch_val[1] = 512; ch_val[2] = 1000; ch_val[3] = 300; ch_val[4] = 900;
        run_scan(1'b1);
        chk("R3 channels converted", n_seen, 5);
        for (int i = 0; i < 5; i++) chk("R3 scan order", seen_ch[i], i);
        rd(6'd0, v); chk("R3 channel field shows highest", v & 15, 4);
        chk("R8 watchdog flag", (v >> 6) & 1, 1);
        rd_wst(w); chk("R7 R8 status only channel 4", w, 32'h010);
        for (int i = 0; i < 5; i++) begin
            rd(6'(16 + 2 * i), v); chk("R4 right high byte", v, exp_hi(ch_val[i], 1'b1));
            rd(6'(17 + 2 * i), v); chk("R4 right low byte", v, exp_lo(ch_val[i], 1'b1));
        end
        chk("R10 irq off with enables clear", int'(irq), 0);

        // R11: no further requests after the scan.
        repeat (20) @(negedge clk);
        chk("R11 single scan per start", n_seen, 5);

        // R8: writing 1 keeps status, writing 0 clears.
        wr(6'd9, 8'hFF); rd_wst(w); chk("R8 write one keeps", w, 32'h010);
        wr(6'd9, 8'hEF); rd_wst(w); chk("R8 write zero clears", w, 0);

        // R9: full-register write clears flags and keeps channel field.
        wr(6'd0, 8'h54); rd(6'd0, v); chk("R9 eoc cleared awd kept", v, 32'h54);
        chk("R10 irq from watchdog source", int'(irq), 1);
        wr(6'd0, 8'h14); rd(6'd0, v); chk("R9 awd cleared", v, 32'h14);
        chk("R10 irq low after clear", int'(irq), 0);
        wr(6'd0, 8'hC4); rd(6'd0, v); chk("R9 writing ones sets nothing", v, 32'h04);

        // R6/R3: window boundaries on a channel-0-only scan.
        set_en(1);
        wr(6'd0, 8'h00);
        for (int k = 0; k < 5; k++) begin
            int smp;
            smp = (k == 0) ? 300 : (k == 1) ? 800 : (k == 2) ? 299 : (k == 3) ? 801 : 550;
            ch_val[0] = smp;
            run_scan(1'b1);
            chk("R3 field zero converts channel 0 only", n_seen, 1);
            rd_wst(w); chk("R6 strict window", w, int'(fires(smp, 300, 800)));
            wr(6'd9, 8'h00);
            wr(6'd0, 8'h00);
        end

        // Random scans with end-of-scan interrupt enabled.
        for (int it = 0; it < 24; it++) begin
            int exp_w;
            last  = $urandom % 10;
            en    = $urandom % 1024;
            lo    = $urandom % 512;
            hi    = 512 + ($urandom % 512);
            right = 1'($urandom % 2);
            exp_w = 0;
            for (int i = 0; i < 10; i++) begin
                case ($urandom % 4)
                    0: ch_val[i] = lo;
                    1: ch_val[i] = hi;
                    default: ch_val[i] = $urandom % 1024;
                endcase
                if (i <= last && en[i] && fires(ch_val[i], lo, hi)) exp_w |= (1 << i);
            end
            set_thr(lo, hi);
            set_en(en);
            wr(6'd8, 8'h00); wr(6'd9, 8'h00);
            wr(6'd0, 8'(32'h20 | last));
            run_scan(right);
            chk("R3 random channel count", n_seen, last + 1);
            for (int i = 0; i <= last; i++) begin
                chk("R3 random order", seen_ch[i], i);
                chk("R5 no end-of-scan before last result", int'(irq_at[i]), 0);
                rd(6'(16 + 2 * i), v); chk("R4 random high byte", v, exp_hi(ch_val[i], right));
                rd(6'(17 + 2 * i), v); chk("R4 random low byte", v, exp_lo(ch_val[i], right));
            end
            chk("R10 irq from end-of-scan", int'(irq), 1);
            rd_wst(w); chk("R6 R7 random status", w, exp_w);
            rd(6'd0, v);
            chk("R8 random watchdog flag", (v >> 6) & 1, int'(exp_w != 0));
            chk("R3 random field restored", v & 15, last);
            wr(6'd0, 8'(last));
        end

        finish_run();
    end
endmodule